// File: doc/BRIEF.md
# Highway and Farm-Road Crossing Signal Controller

This block drives the signal heads at a crossing between a busy highway and a lightly used farm road. A four-phase controller steps through highway go, highway warning, farm go and farm warning, and a single interval timer times every phase. The timer is cleared each time the phase changes and raises a short flag, used to end warning (yellow) phases, and a long flag, used to bound go (green) phases.

The highway keeps its green until a farm-road vehicle is detected and the long interval has also run out. This gives the highway a minimum green time even under heavy cross traffic. The farm road gets green only while a vehicle is detected, and never for longer than the long interval. Both interval lengths are parameters, so a simulation build can use a few cycles where a real build uses many millions. The six lamp drives are registered and follow the phase register by one clock.

Top module: `xing_signal_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, and on the first edge after it falls, the lamps show highway green and farm red, with no other lamp lit.
- R2: Each road always lights exactly one of its three lamps: green, yellow or red.
- R3: When either road shows green or yellow, the other road shows red.
- R4: Highway green ends only when `car_wait` is high and the long interval has run out. With the phase timer cleared on entry, this holds highway green for at least LONG_CYCLES+1 clocks, and for exactly that many when `car_wait` stays high.
- R5: While `car_wait` stays low, highway green holds for as long as that lasts.
- R6: Highway yellow lasts exactly SHORT_CYCLES+1 clocks and is followed by farm green. This holds however long the green before it lasted, because the timer restarts on every phase change.
- R7: During farm green, a clock edge that samples `car_wait` low moves the controller to farm yellow. The lamps show farm yellow from the next edge.
- R8: While `car_wait` stays high, farm green lasts exactly LONG_CYCLES+1 clocks and is then followed by farm yellow.
- R9: Farm yellow lasts exactly SHORT_CYCLES+1 clocks and is followed by highway green.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| car_wait | input | 1 | Farm-road vehicle detected |
| hw_grn | output | 1 | Highway green lamp |
| hw_yel | output | 1 | Highway yellow lamp |
| hw_red | output | 1 | Highway red lamp |
| fr_grn | output | 1 | Farm-road green lamp |
| fr_yel | output | 1 | Farm-road yellow lamp |
| fr_red | output | 1 | Farm-road red lamp |

## Verification
The bench builds the controller with SHORT_CYCLES=3 and LONG_CYCLES=8. With these values a full cycle of the four phases takes a few dozen clocks, so random runs of `car_wait` reach every exit: the car arriving before and after the long limit, the car leaving early during farm green, and farm green reaching its cap. The short gap between the two lengths also exposes any off-by-one in the saturating counter or in the restart on a phase change.

// File: rtl/xing_pkg.sv
package xing_pkg;
   // Phase codes; bit 0 marks the farm road as the road being served.
   typedef enum logic [1:0] {
      PH_HWY_GO   = 2'b00,
      PH_HWY_WARN = 2'b10,
      PH_FARM_GO  = 2'b01,
      PH_FARM_WARN= 2'b11
   } phase_t;

   typedef struct packed {
      logic go;
      logic warn;
      logic stop;
   } lamp_t;

   localparam int ROADS = 2;
   localparam int ROAD_HWY  = 0;
   localparam int ROAD_FARM = 1;
endpackage

// File: rtl/xing_timer.sv
module xing_timer #(
   parameter int SHORT_CYCLES = 4,
   parameter int LONG_CYCLES  = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic tm_short,
   output logic tm_long
);
   localparam int CNT_W = $clog2(LONG_CYCLES + 1);
   localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CYCLES);
   localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYCLES);

   logic [CNT_W-1:0] cnt_q;

   // Saturating up-counter, cleared by reset or a phase change.
   always_ff @(posedge clk) begin
      if (rst || start)
         cnt_q <= '0;
      else if (cnt_q != LONG_V)
         cnt_q <= cnt_q + 1'b1;
   end

   assign tm_short = (cnt_q >= SHORT_V);
   assign tm_long  = (cnt_q == LONG_V);
endmodule

// File: rtl/xing_fsm.sv
module xing_fsm
   import xing_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   car_wait,
   input  logic   tm_short,
   input  logic   tm_long,
   output phase_t phase_q,
   output logic   start
);
   phase_t phase_d;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_HWY_GO:    if (car_wait && tm_long) phase_d = PH_HWY_WARN;
         PH_HWY_WARN:  if (tm_short)            phase_d = PH_FARM_GO;
         PH_FARM_GO:   if (!car_wait || tm_long) phase_d = PH_FARM_WARN;
         PH_FARM_WARN: if (tm_short)            phase_d = PH_HWY_GO;
         default:                               phase_d = PH_HWY_GO;
      endcase
   end

   // Any phase change restarts the interval timer.
   assign start = (phase_d != phase_q);

   always_ff @(posedge clk) begin
      if (rst) phase_q <= PH_HWY_GO;
      else     phase_q <= phase_d;
   end
endmodule

// File: rtl/xing_lamps.sv
module xing_lamps
   import xing_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  phase_t phase,
   output lamp_t  [ROADS-1:0] lamp_q
);
   for (genvar r = 0; r < ROADS; r++) begin : g_road
      localparam phase_t GO_PH   = (r == ROAD_HWY) ? PH_HWY_GO   : PH_FARM_GO;
      localparam phase_t WARN_PH = (r == ROAD_HWY) ? PH_HWY_WARN : PH_FARM_WARN;
      localparam lamp_t  RST_L   = (r == ROAD_HWY) ? lamp_t'(3'b100) : lamp_t'(3'b001);
      lamp_t dec;

      always_comb begin
         dec      = '0;
         dec.go   = (phase == GO_PH);
         dec.warn = (phase == WARN_PH);
         dec.stop = !(dec.go || dec.warn);
      end

      always_ff @(posedge clk) begin
         if (rst) lamp_q[r] <= RST_L;
         else     lamp_q[r] <= dec;
      end
   end
endmodule

// File: rtl/xing_signal_ctrl.sv
module xing_signal_ctrl
   import xing_pkg::*;
#(
   parameter int SHORT_CYCLES = 250_000_000,
   parameter int LONG_CYCLES  = 1_500_000_000
) (
   input  logic clk,
   input  logic rst,
   input  logic car_wait,
   output logic hw_grn,
   output logic hw_yel,
   output logic hw_red,
   output logic fr_grn,
   output logic fr_yel,
   output logic fr_red
);
   if (SHORT_CYCLES < 1) begin : g_bad_short
      $error("xing_signal_ctrl: SHORT_CYCLES must be at least 1");
   end
   if (LONG_CYCLES <= SHORT_CYCLES) begin : g_bad_long
      $error("xing_signal_ctrl: LONG_CYCLES must exceed SHORT_CYCLES");
   end

   phase_t phase_q;
   logic   tm_start, tm_short, tm_long;
   lamp_t  [ROADS-1:0] lamp_q;

   xing_timer #(
      .SHORT_CYCLES(SHORT_CYCLES),
      .LONG_CYCLES (LONG_CYCLES)
   ) i_timer (
      .clk     (clk),
      .rst     (rst),
      .start   (tm_start),
      .tm_short(tm_short),
      .tm_long (tm_long)
   );

   xing_fsm i_fsm (
      .clk     (clk),
      .rst     (rst),
      .car_wait(car_wait),
      .tm_short(tm_short),
      .tm_long (tm_long),
      .phase_q (phase_q),
      .start   (tm_start)
   );

   xing_lamps i_lamps (
      .clk   (clk),
      .rst   (rst),
      .phase (phase_q),
      .lamp_q(lamp_q)
   );

   assign hw_grn = lamp_q[ROAD_HWY].go;
   assign hw_yel = lamp_q[ROAD_HWY].warn;
   assign hw_red = lamp_q[ROAD_HWY].stop;
   assign fr_grn = lamp_q[ROAD_FARM].go;
   assign fr_yel = lamp_q[ROAD_FARM].warn;
   assign fr_red = lamp_q[ROAD_FARM].stop;
endmodule

// File: rtl/xing_chk.sv
module xing_chk
   import xing_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic       car_wait,
   input logic [1:0] phase,
   input logic       tm_start,
   input logic       tm_short,
   input logic       tm_long,
   input logic       hw_grn,
   input logic       hw_yel,
   input logic       hw_red,
   input logic       fr_grn,
   input logic       fr_yel,
   input logic       fr_red
);
   AST_RESET_LAMPS: assert property (@(posedge clk) rst |=> (hw_grn && !hw_yel && !hw_red && fr_red && !fr_grn && !fr_yel)); // R1
   AST_HWY_ONE_HOT: assert property (@(posedge clk) disable iff (rst) $onehot({hw_grn, hw_yel, hw_red})); // R2
   AST_FARM_ONE_HOT: assert property (@(posedge clk) disable iff (rst) $onehot({fr_grn, fr_yel, fr_red})); // R2
   AST_HWY_LIT_FARM_RED: assert property (@(posedge clk) disable iff (rst) (hw_grn || hw_yel) |-> fr_red); // R3
   AST_FARM_LIT_HWY_RED: assert property (@(posedge clk) disable iff (rst) (fr_grn || fr_yel) |-> hw_red); // R3
   AST_HWY_GREEN_HOLD: assert property (@(posedge clk) disable iff (rst) (phase == PH_HWY_GO && !(car_wait && tm_long)) |=> phase == PH_HWY_GO); // R4
   AST_HWY_GREEN_EXIT: assert property (@(posedge clk) disable iff (rst) (phase == PH_HWY_GO && car_wait && tm_long) |=> phase == PH_HWY_WARN); // R4
   AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (rst) tm_start |=> (!tm_short && !tm_long)); // R6
   AST_HWY_WARN_EXIT: assert property (@(posedge clk) disable iff (rst) (phase == PH_HWY_WARN && tm_short) |=> phase == PH_FARM_GO); // R6
   AST_FARM_GREEN_EARLY: assert property (@(posedge clk) disable iff (rst) (phase == PH_FARM_GO && !car_wait) |=> phase == PH_FARM_WARN); // R7
   AST_FARM_GREEN_CAP: assert property (@(posedge clk) disable iff (rst) (phase == PH_FARM_GO && tm_long) |=> phase == PH_FARM_WARN); // R8
   AST_FARM_WARN_EXIT: assert property (@(posedge clk) disable iff (rst) (phase == PH_FARM_WARN && tm_short) |=> phase == PH_HWY_GO); // R9
endmodule

bind xing_signal_ctrl xing_chk i_chk (
   .clk     (clk),
   .rst     (rst),
   .car_wait(car_wait),
   .phase   (phase_q),
   .tm_start(tm_start),
   .tm_short(tm_short),
   .tm_long (tm_long),
   .hw_grn  (hw_grn),
   .hw_yel  (hw_yel),
   .hw_red  (hw_red),
   .fr_grn  (fr_grn),
   .fr_yel  (fr_yel),
   .fr_red  (fr_red)
);

// File: tb/test_xing_signal_ctrl.sv
module test_xing_signal_ctrl;
   localparam int S = 3;
   localparam int L = 8;

   // Bench-side phase codes: 0 hwy green, 1 hwy yellow, 2 farm green, 3 farm yellow
   localparam int P_HG = 0, P_HY = 1, P_FG = 2, P_FY = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic car = 1'b0;
   logic hw_grn, hw_yel, hw_red, fr_grn, fr_yel, fr_red;

   int checks = 0;
   int failures = 0;
   int m_ph = P_HG;
   int m_cnt = 0;
   int hg_run = 0;

   always #5 clk = ~clk;

   xing_signal_ctrl #(.SHORT_CYCLES(S), .LONG_CYCLES(L)) i_xing_signal_ctrl (
      .clk(clk), .rst(rst), .car_wait(car),
      .hw_grn(hw_grn), .hw_yel(hw_yel), .hw_red(hw_red),
      .fr_grn(fr_grn), .fr_yel(fr_yel), .fr_red(fr_red)
   );

   function automatic int next_ph(int ph, logic c, int cnt);
      bit ts = (cnt >= S);
      bit tl = (cnt >= L);
      case (ph)
         P_HG:    return (c && tl) ? P_HY : P_HG;
         P_HY:    return ts ? P_FG : P_HY;
         P_FG:    return (!c || tl) ? P_FY : P_FG;
         default: return ts ? P_HG : P_FY;
      endcase
   endfunction

   // Lamps as {hw_grn,hw_yel,hw_red,fr_grn,fr_yel,fr_red}
   function automatic logic [5:0] lamps_of(int ph);
      case (ph)
         P_HG:    return 6'b100_001;
         P_HY:    return 6'b010_001;
         P_FG:    return 6'b001_100;
         default: return 6'b001_010;
      endcase
   endfunction

   function automatic string req_of(int ph, logic c);
      case (ph)
         P_HG:    return c ? "R4" : "R5";
         P_HY:    return "R6";
         P_FG:    return c ? "R8" : "R7";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [5:0] lamps_now();
      return {hw_grn, hw_yel, hw_red, fr_grn, fr_yel, fr_red};
   endfunction

   // One clock: drive car at a falling edge, model the rising edge, check at next falling edge.
   task automatic step(input logic c);
      int old_ph = m_ph;
      int nph;
      logic [5:0] got;
      car = c;
      nph = next_ph(m_ph, c, m_cnt);
      if (nph != m_ph) m_cnt = 0;
      else if (m_cnt < L) m_cnt++;
      m_ph = nph;
      @(negedge clk);
      got = lamps_now();
      check(req_of(old_ph, c), got, lamps_of(old_ph));
      check("R2", {1'b0, 1'b0, $countones(got[5:3]) == 1, 1'b0, 1'b0, $countones(got[2:0]) == 1}, 6'b001_001);
      check("R3", {5'b0, (got[5] | got[4]) & (got[2] | got[1] | got[0]) & !got[0]}, 6'b0);
      if (got[5]) hg_run++;
      else if (hg_run != 0) begin
         check("R4", {5'b0, hg_run >= L + 1}, 6'b000_001);
         hg_run = 0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      car = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", lamps_now(), 6'b100_001);
      rst = 1'b0;
      m_ph = P_HG;
      m_cnt = 0;
      hg_run = 0;
   endtask

   initial begin : watchdog
      repeat (100_000) @(posedge clk);
      failures++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stim
      int seed = 32'h5EED_1234;
      int dummy = $urandom(seed);
      do_reset();
      // R5: no car, highway stays green well past the long interval
      repeat (3 * L) step(1'b0);
      check("R5", lamps_now(), 6'b100_001);
      // R4/R6/R8/R9: car held throughout a full cycle
      repeat (2 * (L + S + 4)) step(1'b1);
      // R7: car leaves early during farm green
      while (m_ph != P_FG) step(1'b1);
      step(1'b1);
      step(1'b0);
      step(1'b0);
      check("R7", lamps_now(), 6'b001_010);
      repeat (S + 3) step(1'b0);
      // R1: reset in mid-sequence
      repeat (L + 2) step(1'b1);
      do_reset();
      // Random runs of the car input
      for (int i = 0; i < 400; i++) begin
         logic c = 1'($urandom_range(0, 1));
         int len = $urandom_range(1, 14);
         for (int k = 0; k < len; k++) step(c);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule